// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block holds a bank of receive mailboxes behind an already-decoded CAN receive path. Each cycle in which the receive path raises its valid strobe, the block takes the identifier, the extended-format flag, the remote-request flag, the length code and eight data bytes, and places the frame into the lowest-numbered mailbox whose ready flag is clear. A filled mailbox keeps its frame until the host re-arms it by writing a mask, one bit per mailbox. Several mailboxes can be re-armed in one write.

The highest mailbox may be built in overwrite mode. In that mode, a frame that finds every mailbox full replaces the content of the highest mailbox and raises a message-ignored flag there. Built without overwrite mode, such a frame is discarded and a saturating drop counter advances. The host reads any mailbox through a select input as four formatted 32-bit words. The ready flags leave the block as a vector that an interrupt block can use directly as mailbox event bits.

Top module: `rx_mailbox_bank`

## Requirements
- R1: After reset every ready flag and message-ignored flag is clear, the drop counter is zero and every mailbox reads back as all-zero words.
- R2: A frame arriving with rxValid high is written into the lowest-numbered mailbox whose ready flag is clear, and that mailbox's ready flag is set from the next clock edge.
- R3: A mailbox whose ready flag is set keeps its stored frame unchanged while further frames arrive, until it is re-armed.
- R4: With OVERWRITE_LAST=1, a frame arriving while all mailboxes are full replaces the content of mailbox NUM_MB-1 and sets that mailbox's message-ignored flag (status bit 24); its ready flag stays set.
- R5: A cycle with rearmWe high clears the ready flag and the message-ignored flag of every mailbox whose bit is set in rearmMask, and leaves the stored frame fields in place.
- R6: The status word carries the ready flag at bit 23, the message-ignored flag at bit 24, the remote-request flag at bit 20 and the length code in bits 19:16; all other bits read zero.
- R7: The identifier word holds an extended identifier in bits 28:0 with bit 29 set; a standard identifier (rxId[10:0]) is placed in bits 28:18 with bit 29 clear. Bits 31:30 read zero.
- R8: Data byte k arrives on rxData[8k+7:8k]; the low data word returns bytes 0 to 3 and the high data word bytes 4 to 7, byte 0 and byte 4 in bits 7:0.
- R9: With OVERWRITE_LAST=0, a frame that finds every mailbox full is discarded, no mailbox changes, and dropCount increments, saturating at its maximum value.
- R10: When a frame and a re-arm arrive in the same cycle, the mailbox is chosen from the ready flags held before that edge, the re-arm takes effect, and the mailbox written ends up ready.
- R11: readyVec bit i equals the ready flag of mailbox i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Decoded frame present this cycle |
| rxId | input | 29 | Identifier; standard frames use bits 10:0 |
| rxIde | input | 1 | Extended-format identifier |
| rxRtr | input | 1 | Remote-request frame |
| rxDlc | input | 4 | Length code |
| rxData | input | 64 | Data bytes, byte k at bits 8k+7:8k |
| rearmWe | input | 1 | Apply rearmMask this cycle |
| rearmMask | input | NUM_MB | Mailboxes to re-arm |
| rdSel | input | $clog2(NUM_MB) | Mailbox to read |
| rdIdWord | output | 32 | Formatted identifier of the selected mailbox |
| rdStatusWord | output | 32 | Status of the selected mailbox |
| rdDataLo | output | 32 | Data bytes 0 to 3 |
| rdDataHi | output | 32 | Data bytes 4 to 7 |
| readyVec | output | NUM_MB | Per-mailbox ready flags |
| dropCount | output | CNT_W | Saturating count of discarded frames |

## Verification
The bench builds two instances. The default one, twelve mailboxes with the top mailbox in overwrite mode, is filled to capacity so that lowest-free allocation, the overwrite of the top mailbox with its ignored flag, multi-bit re-arm and a re-arm colliding with a frame all come into play. A second instance with four mailboxes, overwrite off and a 2-bit drop counter reaches the discard path after four frames and the counter's saturation after three more.

// File: rtl/rx_mailbox_pkg.sv
package rx_mailbox_pkg;

  // Widest mailbox index carried in the control strobes
  localparam int MBX_IDX_W = 6;

  // Status word field positions
  localparam int ST_DLC_LSB = 16;
  localparam int ST_RTR_BIT = 20;
  localparam int ST_RDY_BIT = 23;
  localparam int ST_IGN_BIT = 24;

  // Identifier word layout
  localparam int ID_IDE_BIT   = 29;
  localparam int STD_ID_SHIFT = 18;

  typedef struct packed {
    logic                 wrEn;
    logic                 setIgn;
    logic [MBX_IDX_W-1:0] wrIdx;
  } mbx_strobe_t;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } rx_frame_t;

endpackage

// File: rtl/rx_mailbox_ctrl.sv
module rx_mailbox_ctrl
  import rx_mailbox_pkg::*;
#(
  parameter int NUM_MB         = 12,
  parameter int OVERWRITE_LAST = 1,
  parameter int CNT_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxValid,
  input  logic              rearmWe,
  input  logic [NUM_MB-1:0] rearmMask,
  output mbx_strobe_t       strobe,
  output logic [NUM_MB-1:0] readyVec,
  output logic [NUM_MB-1:0] ignVec,
  output logic [CNT_W-1:0]  dropCount
);

  localparam int IDX_W = $clog2(NUM_MB);
  localparam int LAST  = NUM_MB - 1;

  logic [NUM_MB-1:0] readyQ, readyD, ignQ, ignD, clrMask;
  logic              freeFound;
  logic [IDX_W-1:0]  freeIdx;
  logic              allFull;

  // Lowest-numbered mailbox with a clear ready flag
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (!readyQ[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  assign allFull = rxValid && !freeFound;

  always_comb begin
    strobe.wrEn   = rxValid && (freeFound || (OVERWRITE_LAST != 0));
    strobe.setIgn = allFull && (OVERWRITE_LAST != 0);
    strobe.wrIdx  = freeFound ? MBX_IDX_W'(freeIdx) : MBX_IDX_W'(LAST);
  end

  assign clrMask = rearmWe ? rearmMask : '0;

  always_comb begin
    readyD = readyQ & ~clrMask;
    ignD   = ignQ & ~clrMask;
    for (int i = 0; i < NUM_MB; i++) begin
      if (strobe.wrEn && strobe.wrIdx == MBX_IDX_W'(i)) readyD[i] = 1'b1;
    end
    if (strobe.setIgn) ignD[LAST] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readyQ <= '0;
      ignQ   <= '0;
    end else begin
      readyQ <= readyD;
      ignQ   <= ignD;
    end
  end

  assign readyVec = readyQ;
  assign ignVec   = ignQ;

  generate
    if (OVERWRITE_LAST != 0) begin : g_noDrop
      assign dropCount = '0;
    end else begin : g_dropCnt
      logic [CNT_W-1:0] dropQ;
      always_ff @(posedge clk) begin
        if (!rst_n) dropQ <= '0;
        else if (allFull && dropQ != {CNT_W{1'b1}}) dropQ <= dropQ + 1'b1;
      end
      assign dropCount = dropQ;
    end
  endgenerate

endmodule

// File: rtl/rx_mailbox_store.sv
module rx_mailbox_store
  import rx_mailbox_pkg::*;
#(
  parameter int NUM_MB = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  mbx_strobe_t                strobe,
  input  rx_frame_t                  frame,
  input  logic [$clog2(NUM_MB)-1:0]  rdSel,
  input  logic [NUM_MB-1:0]          readyVec,
  input  logic [NUM_MB-1:0]          ignVec,
  output logic [31:0]                rdIdWord,
  output logic [31:0]                rdStatusWord,
  output logic [31:0]                rdDataLo,
  output logic [31:0]                rdDataHi
);

  localparam int IDX_W = $clog2(NUM_MB);

  logic [31:0] idQ   [NUM_MB];
  logic        rtrQ  [NUM_MB];
  logic [3:0]  dlcQ  [NUM_MB];
  logic [63:0] dataQ [NUM_MB];
  logic [31:0] idFmt;

  always_comb begin
    idFmt = '0;
    if (frame.ide) begin
      idFmt[28:0]       = frame.id;
      idFmt[ID_IDE_BIT] = 1'b1;
    end else begin
      idFmt[STD_ID_SHIFT +: 11] = frame.id[10:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_MB; i++) begin
      if (!rst_n) begin
        idQ[i]   <= '0;
        rtrQ[i]  <= 1'b0;
        dlcQ[i]  <= '0;
        dataQ[i] <= '0;
      end else if (strobe.wrEn && strobe.wrIdx == MBX_IDX_W'(i)) begin
        idQ[i]   <= idFmt;
        rtrQ[i]  <= frame.rtr;
        dlcQ[i]  <= frame.dlc;
        dataQ[i] <= frame.data;
      end
    end
  end

  always_comb begin
    rdIdWord     = '0;
    rdStatusWord = '0;
    rdDataLo     = '0;
    rdDataHi     = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (rdSel == IDX_W'(i)) begin
        rdIdWord                             = idQ[i];
        rdStatusWord[ST_DLC_LSB +: 4]        = dlcQ[i];
        rdStatusWord[ST_RTR_BIT]             = rtrQ[i];
        rdStatusWord[ST_RDY_BIT]             = readyVec[i];
        rdStatusWord[ST_IGN_BIT]             = ignVec[i];
        rdDataLo                             = dataQ[i][31:0];
        rdDataHi                             = dataQ[i][63:32];
      end
    end
  end

endmodule

// File: rtl/rx_mailbox_bank.sv
module rx_mailbox_bank
  import rx_mailbox_pkg::*;
#(
  parameter int NUM_MB         = 12,
  parameter int OVERWRITE_LAST = 1,
  parameter int CNT_W          = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rxValid,
  input  logic [28:0]               rxId,
  input  logic                      rxIde,
  input  logic                      rxRtr,
  input  logic [3:0]                rxDlc,
  input  logic [63:0]               rxData,
  input  logic                      rearmWe,
  input  logic [NUM_MB-1:0]         rearmMask,
  input  logic [$clog2(NUM_MB)-1:0] rdSel,
  output logic [31:0]               rdIdWord,
  output logic [31:0]               rdStatusWord,
  output logic [31:0]               rdDataLo,
  output logic [31:0]               rdDataHi,
  output logic [NUM_MB-1:0]         readyVec,
  output logic [CNT_W-1:0]          dropCount
);

  mbx_strobe_t       strobe;
  rx_frame_t         frame;
  logic [NUM_MB-1:0] ignVec;

  assign frame = '{id: rxId, ide: rxIde, rtr: rxRtr, dlc: rxDlc, data: rxData};

  rx_mailbox_ctrl #(
    .NUM_MB(NUM_MB), .OVERWRITE_LAST(OVERWRITE_LAST), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rearmWe(rearmWe),
    .rearmMask(rearmMask), .strobe(strobe), .readyVec(readyVec),
    .ignVec(ignVec), .dropCount(dropCount)
  );

  rx_mailbox_store #(.NUM_MB(NUM_MB)) store_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .frame(frame), .rdSel(rdSel),
    .readyVec(readyVec), .ignVec(ignVec), .rdIdWord(rdIdWord),
    .rdStatusWord(rdStatusWord), .rdDataLo(rdDataLo), .rdDataHi(rdDataHi)
  );

endmodule

// File: rtl/rx_mailbox_bank_chk.sv
module rx_mailbox_bank_chk #(
  parameter int NUM_MB         = 12,
  parameter int OVERWRITE_LAST = 1,
  parameter int CNT_W          = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxValid,
  input logic              rearmWe,
  input logic [NUM_MB-1:0] rearmMask,
  input logic [NUM_MB-1:0] readyVec,
  input logic [NUM_MB-1:0] ignVec,
  input logic [CNT_W-1:0]  dropCount
);

  // R2: a frame with a free mailbox fills exactly one more mailbox
  a_r2_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && !rearmWe && !(&readyVec))
    |=> ($countones(readyVec) == $countones($past(readyVec)) + 1));

  // R4: overwrite with all full keeps the top mailbox ready and flags it
  a_r4_overwrite_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((OVERWRITE_LAST != 0) && rxValid && !rearmWe && (&readyVec))
    |=> (ignVec[NUM_MB-1] && (&readyVec)));

  // R4: the ignored flag never stands on an empty mailbox
  a_r4_ign_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ignVec[NUM_MB-1] |-> readyVec[NUM_MB-1]);

  // R5: re-armed mailboxes lose both flags
  a_r5_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rearmWe && !rxValid)
    |=> (((readyVec | ignVec) & $past(rearmMask)) == '0));

  // R9: a discarded frame advances the drop counter
  a_r9_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((OVERWRITE_LAST == 0) && rxValid && !rearmWe && (&readyVec)
     && (dropCount != {CNT_W{1'b1}}))
    |=> (dropCount == $past(dropCount) + 1'b1));

  // R9: the drop counter never goes back
  a_r9_drop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dropCount >= $past(dropCount)));

endmodule

bind rx_mailbox_bank rx_mailbox_bank_chk #(
  .NUM_MB(NUM_MB), .OVERWRITE_LAST(OVERWRITE_LAST), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rearmWe(rearmWe),
  .rearmMask(rearmMask), .readyVec(readyVec), .ignVec(ignVec),
  .dropCount(dropCount)
);

// File: tb/rx_mailbox_bank_tb_top.sv
`timescale 1ns/1ps
module rx_mailbox_bank_tb_top;

  localparam int N  = 12;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxValid = 1'b0, rx2Valid = 1'b0;
  logic [28:0] rxId = '0;
  logic        rxIde = 1'b0, rxRtr = 1'b0;
  logic [3:0]  rxDlc = '0;
  logic [63:0] rxData = '0;
  logic        rearmWe = 1'b0;
  logic [N-1:0] rearmMask = '0;
  logic [IW-1:0] rdSel = '0;
  logic [31:0] rdIdWord, rdStatusWord, rdDataLo, rdDataHi;
  logic [N-1:0] readyVec;
  logic [7:0]  dropCount;

  logic [1:0]  rdSel2 = '0;
  logic [31:0] id2, st2, lo2, hi2;
  logic [3:0]  readyVec2;
  logic [1:0]  dropCount2;

  always #2.5 clk = ~clk;

  rx_mailbox_bank dut_i (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxId(rxId), .rxIde(rxIde),
    .rxRtr(rxRtr), .rxDlc(rxDlc), .rxData(rxData), .rearmWe(rearmWe),
    .rearmMask(rearmMask), .rdSel(rdSel), .rdIdWord(rdIdWord),
    .rdStatusWord(rdStatusWord), .rdDataLo(rdDataLo), .rdDataHi(rdDataHi),
    .readyVec(readyVec), .dropCount(dropCount)
  );

  rx_mailbox_bank #(.NUM_MB(4), .OVERWRITE_LAST(0), .CNT_W(2)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .rxValid(rx2Valid), .rxId(rxId), .rxIde(rxIde),
    .rxRtr(rxRtr), .rxDlc(rxDlc), .rxData(rxData), .rearmWe(1'b0),
    .rearmMask(4'h0), .rdSel(rdSel2), .rdIdWord(id2), .rdStatusWord(st2),
    .rdDataLo(lo2), .rdDataHi(hi2), .readyVec(readyVec2), .dropCount(dropCount2)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Bench model of the default instance
  logic [28:0] mId   [N];
  logic        mIde  [N];
  logic        mRtr  [N];
  logic [3:0]  mDlc  [N];
  logic [63:0] mData [N];
  logic [N-1:0] mRdy = '0;
  logic [N-1:0] mIgn = '0;

  typedef struct {
    int          idx;
    logic [31:0] idW;
    logic [31:0] st;
    logic [31:0] lo;
    logic [31:0] hi;
    string       req;
  } exp_t;
  exp_t q[$];
  int pending = 0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idWordOf(logic [28:0] id, logic ide);
    if (ide) return {2'b00, 1'b1, id};
    return {2'b00, 1'b0, id[10:0], 18'd0};
  endfunction

  task automatic expectMb(int idx, string req);
    exp_t e;
    e.idx = idx;
    e.idW = idWordOf(mId[idx], mIde[idx]);
    e.st  = 32'd0;
    e.st[23] = mRdy[idx];
    e.st[24] = mIgn[idx];
    e.st[20] = mRtr[idx];
    e.st[19:16] = mDlc[idx];
    e.lo  = mData[idx][31:0];
    e.hi  = mData[idx][63:32];
    e.req = req;
    q.push_back(e);
    pending++;
  endtask

  task automatic drain();
    wait (pending == 0);
  endtask

  // Monitor: reads back the mailbox named by each expected item
  initial begin
    forever begin
      wait (pending > 0);
      @(negedge clk);
      rdSel = IW'(q[0].idx);
      #1;
      check(q[0].req, "id word",     {32'd0, rdIdWord},     {32'd0, q[0].idW});
      check(q[0].req, "status word", {32'd0, rdStatusWord}, {32'd0, q[0].st});
      check(q[0].req, "data lo",     {32'd0, rdDataLo},     {32'd0, q[0].lo});
      check(q[0].req, "data hi",     {32'd0, rdDataHi},     {32'd0, q[0].hi});
      void'(q.pop_front());
      pending--;
    end
  end

  // Driver: one frame, optionally with a re-arm in the same cycle
  task automatic sendFrame(logic [28:0] id, logic ide, logic rtr, logic [3:0] dlc,
                           logic [63:0] data, logic [N-1:0] mask, string req);
    int idx;
    bit found;
    @(negedge clk);
    rxValid = 1'b1; rxId = id; rxIde = ide; rxRtr = rtr; rxDlc = dlc; rxData = data;
    rearmWe = (mask != '0); rearmMask = mask;
    found = 1'b0; idx = N - 1;
    for (int i = N - 1; i >= 0; i--) if (!mRdy[i]) begin found = 1'b1; idx = i; end
    mRdy = mRdy & ~mask;
    mIgn = mIgn & ~mask;
    mId[idx] = id; mIde[idx] = ide; mRtr[idx] = rtr; mDlc[idx] = dlc; mData[idx] = data;
    mRdy[idx] = 1'b1;
    if (!found) mIgn[N-1] = 1'b1;
    @(negedge clk);
    rxValid = 1'b0; rearmWe = 1'b0; rearmMask = '0;
    expectMb(idx, req);
    drain();
  endtask

  task automatic rearm(logic [N-1:0] mask);
    @(negedge clk);
    rearmWe = 1'b1; rearmMask = mask;
    mRdy = mRdy & ~mask;
    mIgn = mIgn & ~mask;
    @(negedge clk);
    rearmWe = 1'b0; rearmMask = '0;
  endtask

  task automatic sendSmall(logic [28:0] id);
    @(negedge clk);
    rx2Valid = 1'b1; rxId = id; rxIde = 1'b0; rxRtr = 1'b0; rxDlc = 4'd2;
    rxData = 64'h0;
    @(negedge clk);
    rx2Valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mId[i] = '0; mIde[i] = 1'b0; mRtr[i] = 1'b0; mDlc[i] = '0; mData[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "readyVec", {52'd0, readyVec}, 64'd0);
    check("R1", "dropCount", {56'd0, dropCount}, 64'd0);
    check("R1", "small readyVec", {60'd0, readyVec2}, 64'd0);
    expectMb(0, "R1");
    expectMb(N - 1, "R1");
    drain();

    // R2 R6 R7 R8: standard then extended remote frame
    sendFrame(29'h0000_0123, 1'b0, 1'b0, 4'd8, 64'h8877_6655_4433_2211, '0, "R2_R7_R8");
    sendFrame(29'h1ABC_DEF5, 1'b1, 1'b1, 4'd3, 64'h0102_0304_0506_0708, '0, "R6_R7");
    check("R11", "readyVec", {52'd0, readyVec}, {52'd0, mRdy});

    // R5: single re-arm, then R2: next frame goes back to mailbox 0
    rearm(12'h001);
    check("R5", "readyVec after rearm", {52'd0, readyVec}, 64'h002);
    sendFrame(29'h0000_07FF, 1'b0, 1'b0, 4'd15, 64'hFFEE_DDCC_BBAA_9988, '0, "R2");

    // Fill the rest of the bank
    for (int k = 0; k < 10; k++)
      sendFrame(29'(32'h100 + k), 1'b0, k[0], 4'(k), {32'(k), 32'hA5A5_0000 | 32'(k)}, '0, "R2");
    check("R11", "readyVec full", {52'd0, readyVec}, 64'hFFF);

    // R4: overwrite of the top mailbox; R3: mailbox 0 untouched
    sendFrame(29'h0ABC_1234, 1'b1, 1'b0, 4'd6, 64'hDEAD_BEEF_CAFE_F00D, '0, "R4");
    expectMb(0, "R3");
    expectMb(5, "R3");
    drain();
    check("R4", "readyVec still full", {52'd0, readyVec}, 64'hFFF);

    // R5: multi-bit re-arm clears ready and ignored flags, keeps fields
    rearm(12'h801);
    check("R5", "readyVec after multi rearm", {52'd0, readyVec}, 64'h7FE);
    expectMb(N - 1, "R5");
    expectMb(0, "R5");
    drain();

    // R10: frame and re-arm of mailbox 3 together -> mailbox 0 chosen
    sendFrame(29'h0000_0055, 1'b0, 1'b1, 4'd1, 64'h0000_0000_0000_00AB, 12'h008, "R10");
    check("R10", "readyVec", {52'd0, readyVec}, 64'h7F7);
    expectMb(3, "R10");
    drain();

    // R9: discard path on the four-mailbox instance
    for (int k = 0; k < 4; k++) sendSmall(29'(k + 1));
    check("R9", "small readyVec full", {60'd0, readyVec2}, 64'hF);
    check("R9", "small dropCount none", {62'd0, dropCount2}, 64'd0);
    rdSel2 = 2'd0;
    #1;
    check("R9", "small mb0 id before drop", {32'd0, id2}, {32'd0, idWordOf(29'd1, 1'b0)});
    sendSmall(29'h3F);
    check("R9", "small dropCount one", {62'd0, dropCount2}, 64'd1);
    check("R9", "small readyVec unchanged", {60'd0, readyVec2}, 64'hF);
    rdSel2 = 2'd3;
    #1;
    check("R9", "small mb3 id kept", {32'd0, id2}, {32'd0, idWordOf(29'd4, 1'b0)});
    for (int k = 0; k < 3; k++) sendSmall(29'h3F);
    check("R9", "small dropCount saturated", {62'd0, dropCount2}, 64'd3);
    check("R4", "default dropCount idle", {56'd0, dropCount}, 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule